// File: doc/BRIEF.md
# Virtual Interrupt Flag Unit

This block holds the interrupt-enable flag, its virtual shadow and the virtual-pending flag for a processor core that runs 16-bit guest code. It carries out the four mask-flag operations: clear-enable, set-enable, push-flags and pop-flags. When virtualization is on, these operations act on the shadow flag and the real interrupt-enable flag is left alone. This lets a guest turn its own interrupt masking on and off without trapping to a monitor on every instruction.

Each operation arrives as one strobe bit in a one-hot vector. A pop also presents the 16-bit word it read from the stack. A push returns a 16-bit flags image built from the surrounding flag bits, with the enable position filled by the flag that the current mode exposes. Monitor software holds the virtual-pending flag and writes it through a dedicated port. If the guest tries to enable interrupts while that flag is set, the unit refuses and raises a general-protection fault request so that the monitor can deliver the deferred interrupt.

The mode comes from two inputs: the 2-bit privilege field and the virtualization enable. A privilege field of 3 gives direct operation on the real flag. A field below 3 with the enable set gives virtual operation. A field below 3 with the enable clear blocks every operation with a fault.

Top module: `vif_unit`

## Requirements
- R1: The mode is decoded from `iopl` (2 bits) and `vme`. `iopl`==3 selects direct mode. `iopl`<3 with `vme`=1 selects virtual mode. `iopl`<3 with `vme`=0 selects blocked mode. The strobe bits of `op_strobe` are: bit 0 clear-enable, bit 1 set-enable, bit 2 push, bit 3 pop.
- R2: In virtual mode, clear-enable clears `vif_q`. Set-enable with `vip_q`=0 sets `vif_q`. Neither changes `if_q`, and neither raises a fault.
- R3: A push in direct or virtual mode loads `push_img` with `flags_base`, with bit 9 replaced by `if_q` (direct mode) or `vif_q` (virtual mode). No other operation changes `push_img`.
- R4: In virtual mode, a pop copies bit 9 of `pop_value` into `vif_q` and leaves `if_q` unchanged, unless R5 applies.
- R5: In virtual mode with `vip_q`=1, a set-enable, or a pop whose bit 9 is 1, raises `fault` and leaves `vif_q` and `if_q` unchanged.
- R6: `vip_q` changes only through the write port: when `vip_wr_en`=1, `vip_q` takes `vip_wr_val` at the next edge. No operation changes it.
- R7: In blocked mode, every valid operation raises `fault` and leaves `if_q`, `vif_q` and `push_img` unchanged.
- R8: In direct mode, clear-enable clears `if_q`, set-enable sets it, and pop copies bit 9 of `pop_value` into it. `vif_q` stays unchanged and no fault is raised.
- R9: A pop whose bit 9 is 0 never faults in virtual mode, even with `vip_q`=1, and it clears `vif_q`.
- R10: Flag and image updates appear at the first rising edge after the strobe. `fault` is high for exactly the one cycle after a faulting strobe. A strobe vector that is not one-hot is ignored entirely.
- R11: After reset, `if_q`, `vif_q`, `vip_q`, `fault` and `push_img` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iopl | input | 2 | Current I/O privilege field |
| vme | input | 1 | Virtualization enable |
| op_strobe | input | 4 | One-hot operation strobe (clear, set, push, pop) |
| pop_value | input | 16 | Word read by a pop operation |
| flags_base | input | 16 | Surrounding flag bits used for the push image |
| vip_wr_en | input | 1 | Software write enable for the pending flag |
| vip_wr_val | input | 1 | Value written to the pending flag |
| if_q | output | 1 | Real interrupt-enable flag |
| vif_q | output | 1 | Virtual interrupt-enable flag |
| vip_q | output | 1 | Virtual interrupt-pending flag |
| push_img | output | 16 | Flags image produced by the last push |
| fault | output | 1 | General-protection fault request pulse |

## Verification
Every result of this block is registered once. The flags, the push image and the fault pulse therefore all become visible one rising edge after the cycle that presents the strobe. A pending-flag write lands on that same edge. The bench drives each stimulus on a falling edge and samples on the next falling edge. It then checks one more falling edge later that the fault has dropped again. The sweep covers every combination of mode, starting flags, pending flag, operation and popped bit.

// File: rtl/vifu_pkg.sv
package vifu_pkg;
  localparam int FLAGS_W  = 16;
  localparam int IF_POS   = 9;
  localparam int IOPL_W   = 2;
  localparam int OP_N     = 4;
  localparam int OP_CLR   = 0;
  localparam int OP_SET   = 1;
  localparam int OP_PUSH  = 2;
  localparam int OP_POP   = 3;
  localparam logic [IOPL_W-1:0] IOPL_TOP = '1;

  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'd0,
    MODE_VIRTUAL = 2'd1,
    MODE_BLOCKED = 2'd2
  } vifu_mode_e;
endpackage

// File: rtl/vifu_mode_sel.sv
module vifu_mode_sel
  import vifu_pkg::*;
#(
  parameter int PL_W = IOPL_W
) (
  input  logic [PL_W-1:0] iopl,
  input  logic            vme,
  output vifu_mode_e      mode
);
  localparam logic [PL_W-1:0] PL_MAX = '1;

  always_comb begin
    if (iopl == PL_MAX)  mode = MODE_DIRECT;
    else if (vme)        mode = MODE_VIRTUAL;
    else                 mode = MODE_BLOCKED;
  end
endmodule

// File: rtl/vifu_next.sv
module vifu_next
  import vifu_pkg::*;
#(
  parameter int W     = FLAGS_W,
  parameter int EPOS  = IF_POS,
  parameter int NOPS  = OP_N
) (
  input  vifu_mode_e       mode,
  input  logic [NOPS-1:0]  op_strobe,
  input  logic [W-1:0]     pop_value,
  input  logic [W-1:0]     flags_base,
  input  logic             if_cur,
  input  logic             vif_cur,
  input  logic             vip_cur,
  output logic             if_en,
  output logic             if_d,
  output logic             vif_en,
  output logic             vif_d,
  output logic             img_en,
  output logic [W-1:0]     img_d,
  output logic             fault_d
);
  logic op_ok;
  logic do_clr, do_set, do_push, do_pop;
  logic pop_bit, want_enable, exposed;

  always_comb begin
    op_ok   = ($countones(op_strobe) == 1);
    do_clr  = op_ok & op_strobe[OP_CLR];
    do_set  = op_ok & op_strobe[OP_SET];
    do_push = op_ok & op_strobe[OP_PUSH];
    do_pop  = op_ok & op_strobe[OP_POP];
    pop_bit = pop_value[EPOS];
    want_enable = do_set | (do_pop & pop_bit);

    if_en   = 1'b0;
    if_d    = if_cur;
    vif_en  = 1'b0;
    vif_d   = vif_cur;
    img_en  = 1'b0;
    fault_d = 1'b0;
    exposed = if_cur;

    unique case (mode)
      MODE_DIRECT: begin
        exposed = if_cur;
        img_en  = do_push;
        if_en   = do_clr | do_set | do_pop;
        if (do_set)      if_d = 1'b1;
        else if (do_pop) if_d = pop_bit;
        else             if_d = 1'b0;
      end
      MODE_VIRTUAL: begin
        exposed = vif_cur;
        img_en  = do_push;
        if (want_enable && vip_cur) begin
          fault_d = 1'b1;
        end else begin
          vif_en = do_clr | do_set | do_pop;
          if (do_set)      vif_d = 1'b1;
          else if (do_pop) vif_d = pop_bit;
          else             vif_d = 1'b0;
        end
      end
      default: begin
        fault_d = op_ok;
      end
    endcase

    img_d       = flags_base;
    img_d[EPOS] = exposed;
  end
endmodule

// File: rtl/vifu_regs.sv
module vifu_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         if_en,
  input  logic         if_d,
  input  logic         vif_en,
  input  logic         vif_d,
  input  logic         vip_en,
  input  logic         vip_d,
  input  logic         img_en,
  input  logic [W-1:0] img_d,
  input  logic         fault_d,
  output logic         if_q,
  output logic         vif_q,
  output logic         vip_q,
  output logic [W-1:0] img_q,
  output logic         fault_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_q <= 1'b0;
    end else if (if_en) begin
      if_q <= if_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vif_q <= 1'b0;
    end else if (vif_en) begin
      vif_q <= vif_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vip_q <= 1'b0;
    end else if (vip_en) begin
      vip_q <= vip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q <= '0;
    end else if (img_en) begin
      img_q <= img_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_d;
    end
  end
endmodule

// File: rtl/vif_unit.sv
module vif_unit
  import vifu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IOPL_W-1:0]   iopl,
  input  logic                vme,
  input  logic [OP_N-1:0]     op_strobe,
  input  logic [FLAGS_W-1:0]  pop_value,
  input  logic [FLAGS_W-1:0]  flags_base,
  input  logic                vip_wr_en,
  input  logic                vip_wr_val,
  output logic                if_q,
  output logic                vif_q,
  output logic                vip_q,
  output logic [FLAGS_W-1:0]  push_img,
  output logic                fault
);
  vifu_mode_e          mode;
  logic                if_en, if_d, vif_en, vif_d, img_en, fault_d;
  logic [FLAGS_W-1:0]  img_d;

  vifu_mode_sel #(.PL_W(IOPL_W)) u_mode (
    .iopl (iopl),
    .vme  (vme),
    .mode (mode)
  );

  vifu_next #(.W(FLAGS_W), .EPOS(IF_POS), .NOPS(OP_N)) u_next (
    .mode       (mode),
    .op_strobe  (op_strobe),
    .pop_value  (pop_value),
    .flags_base (flags_base),
    .if_cur     (if_q),
    .vif_cur    (vif_q),
    .vip_cur    (vip_q),
    .if_en      (if_en),
    .if_d       (if_d),
    .vif_en     (vif_en),
    .vif_d      (vif_d),
    .img_en     (img_en),
    .img_d      (img_d),
    .fault_d    (fault_d)
  );

  vifu_regs #(.W(FLAGS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .if_en   (if_en),
    .if_d    (if_d),
    .vif_en  (vif_en),
    .vif_d   (vif_d),
    .vip_en  (vip_wr_en),
    .vip_d   (vip_wr_val),
    .img_en  (img_en),
    .img_d   (img_d),
    .fault_d (fault_d),
    .if_q    (if_q),
    .vif_q   (vif_q),
    .vip_q   (vip_q),
    .img_q   (push_img),
    .fault_q (fault)
  );
endmodule

// File: rtl/vif_unit_chk.sv
module vif_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  iopl,
  input logic        vme,
  input logic [3:0]  op_strobe,
  input logic [15:0] pop_value,
  input logic        vip_wr_en,
  input logic        if_q,
  input logic        vif_q,
  input logic        vip_q,
  input logic [15:0] push_img,
  input logic        fault
);
  logic one_op;
  logic virt;
  logic enable_try;
  assign one_op = ($countones(op_strobe) == 1);
  assign virt   = vme && (iopl != 2'd3);
  assign enable_try = op_strobe[1] || (op_strobe[3] && pop_value[9]);

  AST_VIRT_IF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (virt && one_op) |=> (if_q == $past(if_q))); // R2

  AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (virt && one_op && vip_q && enable_try) |=> (fault && vif_q == $past(vif_q))); // R5

  AST_VIP_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !vip_wr_en |=> $stable(vip_q)); // R6

  AST_BLOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!vme && iopl != 2'd3 && one_op) |=> (fault && $stable(if_q) && $stable(vif_q) && $stable(push_img))); // R7

  AST_DIRECT_VIF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (iopl == 2'd3) |=> ($stable(vif_q) && !fault)); // R8

  AST_FAULT_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(one_op)); // R10

  AST_CLEAR_POP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (virt && op_strobe == 4'b1000 && !pop_value[9]) |=> (!fault && !vif_q)); // R9
endmodule

bind vif_unit vif_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iopl      (iopl),
  .vme       (vme),
  .op_strobe (op_strobe),
  .pop_value (pop_value),
  .vip_wr_en (vip_wr_en),
  .if_q      (if_q),
  .vif_q     (vif_q),
  .vip_q     (vip_q),
  .push_img  (push_img),
  .fault     (fault)
);

// File: tb/vif_unit_tb.sv
module vif_unit_tb;
  logic        clk;
  logic        rst_n;
  logic [1:0]  iopl;
  logic        vme;
  logic [3:0]  op_strobe;
  logic [15:0] pop_value;
  logic [15:0] flags_base;
  logic        vip_wr_en;
  logic        vip_wr_val;
  logic        if_q, vif_q, vip_q, fault;
  logic [15:0] push_img;

  int n_run;
  int n_fail;
  logic [15:0] exp_img;

  vif_unit u_dut (
    .clk(clk), .rst_n(rst_n), .iopl(iopl), .vme(vme), .op_strobe(op_strobe),
    .pop_value(pop_value), .flags_base(flags_base), .vip_wr_en(vip_wr_en),
    .vip_wr_val(vip_wr_val), .if_q(if_q), .vif_q(vif_q), .vip_q(vip_q),
    .push_img(push_img), .fault(fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_op(input logic [1:0] pl, input logic en, input logic [3:0] op,
                         input logic [15:0] pv);
    @(negedge clk);
    iopl = pl; vme = en; op_strobe = op; pop_value = pv;
    @(negedge clk);
    op_strobe = 4'b0000;
  endtask

  task automatic write_vip(input logic v);
    @(negedge clk);
    vip_wr_en = 1'b1; vip_wr_val = v;
    @(negedge clk);
    vip_wr_en = 1'b0;
  endtask

  task automatic set_state(input logic i, input logic v, input logic p);
    write_vip(1'b0);
    step_op(2'd3, 1'b0, i ? 4'b0010 : 4'b0001, 16'h0);
    step_op(2'd0, 1'b1, v ? 4'b0010 : 4'b0001, 16'h0);
    write_vip(p);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; iopl = 2'd0; vme = 1'b0; op_strobe = 4'b0;
    pop_value = 16'h0; flags_base = 16'h0; vip_wr_en = 1'b0; vip_wr_val = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 if", if_q, 0); chk("R11 vif", vif_q, 0); chk("R11 vip", vip_q, 0);
    chk("R11 fault", fault, 0); chk("R11 img", push_img, 0);
    rst_n = 1'b1;
    exp_img = 16'h0;

    // R6: software write lands on the next edge
    @(negedge clk);
    vip_wr_en = 1'b1; vip_wr_val = 1'b1;
    @(negedge clk);
    vip_wr_en = 1'b0;
    chk("R6 vip write 1", vip_q, 1);
    write_vip(1'b0);
    chk("R6 vip write 0", vip_q, 0);

    // Sweep of R1..R10
    for (int pl = 0; pl < 4; pl++)
      for (int en = 0; en < 2; en++)
        for (int si = 0; si < 2; si++)
          for (int sv = 0; sv < 2; sv++)
            for (int sp = 0; sp < 2; sp++)
              for (int k = 0; k < 5; k++) begin
                logic [3:0]  op;
                logic [15:0] pv, base, img_e;
                logic        e_if, e_vif, e_flt, want;
                int          md;
                set_state(si[0], sv[0], sp[0]);
                op = (k == 0) ? 4'b0001 : (k == 1) ? 4'b0010 : (k == 2) ? 4'b0100 : 4'b1000;
                pv = (k == 4) ? 16'hFFFF : 16'hFDFF;
                base = 16'h5A3C ^ 16'(pl * 97 + en * 13 + k * 7 + sp);
                md = (pl == 3) ? 0 : (en == 1) ? 1 : 2;
                e_if = si[0]; e_vif = sv[0]; e_flt = 1'b0; img_e = exp_img;
                want = (k == 1) || (k == 4);
                if (md == 0) begin
                  if (k == 0) e_if = 1'b0;
                  if (k == 1) e_if = 1'b1;
                  if (k >= 3) e_if = (k == 4);
                  if (k == 2) begin img_e = base; img_e[9] = si[0]; end
                end else if (md == 1) begin
                  if (want && sp == 1) e_flt = 1'b1;
                  else begin
                    if (k == 0) e_vif = 1'b0;
                    if (k == 1) e_vif = 1'b1;
                    if (k >= 3) e_vif = (k == 4);
                  end
                  if (k == 2) begin img_e = base; img_e[9] = sv[0]; end
                end else begin
                  e_flt = 1'b1;
                end
                @(negedge clk);
                flags_base = base;
                iopl = 2'(pl); vme = en[0]; op_strobe = op; pop_value = pv;
                @(negedge clk);
                op_strobe = 4'b0000;
                // checks due one edge after the strobe (R10)
                if (md == 0) begin
                  chk("R8/R1 if direct", if_q, e_if);
                  chk("R8 vif held", vif_q, e_vif);
                end else if (md == 1) begin
                  if (k == 3) chk("R9 pop clear", vif_q, e_vif);
                  else if (e_flt) chk("R5 vif held", vif_q, e_vif);
                  else if (k >= 3) chk("R4 pop vif", vif_q, e_vif);
                  else chk("R2 clr/set vif", vif_q, e_vif);
                  chk("R2/R4 if held", if_q, e_if);
                end else begin
                  chk("R7 if frozen", if_q, e_if);
                  chk("R7 vif frozen", vif_q, e_vif);
                end
                chk("R6 vip untouched", vip_q, sp);
                chk("R3 push image", push_img, img_e);
                chk((md == 1 && k == 3) ? "R9 fault" : (md == 2) ? "R7 fault" : "R5 fault",
                    fault, e_flt);
                exp_img = img_e;
                @(negedge clk);
                chk("R10 fault one cycle", fault, 0);
              end

    // R10: non-one-hot strobe ignored
    set_state(1'b1, 1'b0, 1'b0);
    step_op(2'd0, 1'b0, 4'b0011, 16'h0);
    chk("R10 multi strobe fault", fault, 0);
    chk("R10 multi strobe if", if_q, 1);
    step_op(2'd0, 1'b1, 4'b0110, 16'h0);
    chk("R10 multi strobe vif", vif_q, 0);
    chk("R10 multi strobe img", push_img, exp_img);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule